// File: doc/BRIEF.md
# Reset Cause Recorder with Delayed Reset Request

This block records which reset sources have fired and makes that record readable over a small word-addressed register port. It holds two views. The last-cause word shows only the most recent cause. The sticky word gathers causes over time until software clears them. There are eleven sources: low voltage, loss of clock, loss of lock, watchdog, external pin, power-on, JTAG, core lockup, software request, debugger request and stop-acknowledge error. Each source arrives as a one-cycle pulse on its own bit of the event input. Detecting the events is not part of this block.

Each source has an interrupt enable, and a global enable sits above them all. When an event is enabled, the interrupt line rises. A delay counter then starts and counts ticks of a low-power oscillator enable. When the selected count is reached, the block issues a one-cycle reset request and drops the interrupt. Software can use that window to save state before the system reset lands.

Top module: `reset_cause_rec`

## Requirements
- R1: Status bit positions: 1 low voltage, 2 loss of clock, 3 loss of lock, 5 watchdog, 6 external pin, 7 power-on, 8 JTAG, 9 core lockup, 10 software request, 11 debugger request, 13 stop-acknowledge error. Event input bit n drives status bit n. Bits 0, 4 and 12 of the event input are ignored, and a cycle with no valid event changes nothing. Status bits 0, 4, 12 and 14..31 read 0.
- R2: Offset 0x00 reads {major[31:24], minor[23:16], feature[15:0]}, with feature 11 by default. Offset 0x04 reads a 1 at each implemented status position (0x2FEE by default).
- R3: A power-on event (bit 7) sets both the last-cause word (0x08) and the sticky word (0x18) to 0x82, whatever else fires in the same cycle.
- R4: Any other valid event replaces the last-cause word with the bits that fired. The same bits are ORed into the sticky word.
- R5: Writing to 0x18 clears every sticky bit that is written as 1. Writes to 0x08 have no effect.
- R6: If an event and a sticky clear fall in the same cycle, the event bit ends up set.
- R7: The enable register at 0x1C keeps only the writable bits 0,1,2,3,5,6,7,8,9,10,11 and 13 (mask 0x2FEF). All its other bits read 0.
- R8: The interrupt rises in the cycle after an event only if enable bit 7 (global) and the event's own enable bit are both set. Only sources 2,3,5,6,8,9,10,11 and 13 can interrupt.
- R9: Enable bits [1:0] select the delay: 00 = 10, 01 = 34, 10 = 130, 11 = 514 oscillator ticks. The reset request is a one-cycle pulse in the cycle after the last tick, and the interrupt drops in that same cycle.
- R10: While the delay runs, new events do not restart or stop it. They are still recorded in status.
- R11: After reset, all registers read 0 apart from the version and parameter words, and the interrupt and reset request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | One-cycle cause pulses, one bit per status position |
| lpo_tick_i | input | 1 | Low-power oscillator tick enable |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Reset-pending interrupt |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
Two functions can fall in the same cycle: a software clear of a sticky bit and a new event on that same bit. The bench drives the write strobe to 0x18 in the same cycle as the event pulse, with a clear mask that includes the event bit. It passes if the event bit reads back as 1 and the other cleared bit reads back as 0. A second overlap is an event arriving during a running delay. The bench checks that the reset request still appears after exactly the original number of ticks.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned BIT_LVD = 1;
  localparam int unsigned BIT_POR = 7;
  localparam int unsigned BIT_GIE = 7;

  localparam logic [7:0] OFS_VER    = 8'h00;
  localparam logic [7:0] OFS_PARAM  = 8'h04;
  localparam logic [7:0] OFS_LAST   = 8'h08;
  localparam logic [7:0] OFS_STICKY = 8'h18;
  localparam logic [7:0] OFS_IEN    = 8'h1C;

  localparam logic [31:0] STAT_MASK = 32'h0000_2FEE;
  localparam logic [31:0] IEN_MASK  = 32'h0000_2FEF;
  localparam logic [31:0] IRQ_SRC   = 32'h0000_2F6C;

  typedef enum logic {TMR_IDLE, TMR_RUN} tmr_state_e;
endpackage

// File: rtl/rcr_status.sv
module rcr_status #(
  parameter int unsigned EVT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic [EVT_W-1:0] clr_mask_i,
  output logic [EVT_W-1:0] last_o,
  output logic [EVT_W-1:0] sticky_o
);
  import rcr_pkg::*;

  localparam logic [EVT_W-1:0] POR_WORD =
    EVT_W'((32'd1 << BIT_LVD) | (32'd1 << BIT_POR));

  logic [EVT_W-1:0] last_q, sticky_q, sticky_clr;

  assign sticky_clr = clr_we_i ? (sticky_q & ~clr_mask_i) : sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= '0;
      sticky_q <= '0;
    end else if (evt_i[BIT_POR]) begin
      last_q   <= POR_WORD;
      sticky_q <= POR_WORD;
    end else if (|evt_i) begin
      last_q   <= evt_i;
      sticky_q <= sticky_clr | evt_i;  // event wins over clear
    end else begin
      sticky_q <= sticky_clr;
    end
  end

  assign last_o   = last_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/rcr_delay_timer.sv
module rcr_delay_timer #(
  parameter int unsigned DLY0 = 10,
  parameter int unsigned DLY1 = 34,
  parameter int unsigned DLY2 = 130,
  parameter int unsigned DLY3 = 514,
  parameter int unsigned CNT_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       irq_o,
  output logic       req_o
);
  import rcr_pkg::*;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, load_val;
  logic             req_q;

  always_comb begin
    unique case (sel_i)
      2'b00:   load_val = CNT_W'(DLY0);
      2'b01:   load_val = CNT_W'(DLY1);
      2'b10:   load_val = CNT_W'(DLY2);
      default: load_val = CNT_W'(DLY3);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        TMR_IDLE: if (start_i) begin
          state_q <= TMR_RUN;
          cnt_q   <= load_val;
        end
        TMR_RUN: if (tick_i) begin  // start_i ignored while running
          if (cnt_q <= CNT_W'(1)) begin
            state_q <= TMR_IDLE;
            req_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= TMR_IDLE;
      endcase
    end
  end

  assign irq_o = (state_q == TMR_RUN);
  assign req_o = req_q;
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ver_i,
  input  logic [DATA_W-1:0] param_i,
  input  logic [EVT_W-1:0]  last_i,
  input  logic [EVT_W-1:0]  sticky_i,
  input  logic [DATA_W-1:0] ien_i,
  output logic [DATA_W-1:0] rdata_o
);
  import rcr_pkg::*;

  localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] A_PARAM  = ADDR_W'(OFS_PARAM);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(OFS_LAST);
  localparam logic [ADDR_W-1:0] A_STICKY = ADDR_W'(OFS_STICKY);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_VER:    rdata_o = ver_i;
      A_PARAM:  rdata_o = param_i;
      A_LAST:   rdata_o = DATA_W'(last_i);
      A_STICKY: rdata_o = DATA_W'(sticky_i);
      A_IEN:    rdata_o = ien_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/reset_cause_rec.sv
module reset_cause_rec #(
  parameter int unsigned      ADDR_W      = 5,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      EVT_W       = 14,
  parameter logic [7:0]       VER_MAJOR   = 8'd1,
  parameter logic [7:0]       VER_MINOR   = 8'd0,
  parameter logic [15:0]      VER_FEATURE = 16'd11,
  parameter logic [EVT_W-1:0] IMPL_MASK   = 14'h2FEE,
  parameter int unsigned      DLY0        = 10,
  parameter int unsigned      DLY1        = 34,
  parameter int unsigned      DLY2        = 130,
  parameter int unsigned      DLY3        = 514
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              lpo_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  import rcr_pkg::*;

  localparam int unsigned DLY_M01 = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int unsigned DLY_M23 = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int unsigned DLY_MAX = (DLY_M01 > DLY_M23) ? DLY_M01 : DLY_M23;
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);

  localparam logic [EVT_W-1:0]  VALID_MASK = IMPL_MASK & STAT_MASK[EVT_W-1:0];
  localparam logic [EVT_W-1:0]  SRC_MASK   = IRQ_SRC[EVT_W-1:0];
  localparam logic [DATA_W-1:0] VER_WORD   = DATA_W'({VER_MAJOR, VER_MINOR, VER_FEATURE});
  localparam logic [DATA_W-1:0] PARAM_WORD = DATA_W'(VALID_MASK);
  localparam logic [ADDR_W-1:0] A_STICKY   = ADDR_W'(OFS_STICKY);
  localparam logic [ADDR_W-1:0] A_IEN      = ADDR_W'(OFS_IEN);

  logic [EVT_W-1:0]  evt_m, last_w, sticky_w;
  logic [DATA_W-1:0] ien_q;
  logic              clr_we, ien_we, start;

  assign evt_m  = evt_i & VALID_MASK;
  assign clr_we = reg_wr_i && (reg_addr_i == A_STICKY);
  assign ien_we = reg_wr_i && (reg_addr_i == A_IEN);
  assign start  = ien_q[BIT_GIE] && |(evt_m & ien_q[EVT_W-1:0] & SRC_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (ien_we) ien_q <= reg_wdata_i & DATA_W'(IEN_MASK);
  end

  rcr_status #(.EVT_W(EVT_W)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_m),
    .clr_we_i   (clr_we),
    .clr_mask_i (reg_wdata_i[EVT_W-1:0]),
    .last_o     (last_w),
    .sticky_o   (sticky_w)
  );

  rcr_delay_timer #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3), .CNT_W(CNT_W)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .sel_i   (ien_q[1:0]),
    .tick_i  (lpo_tick_i),
    .irq_o   (irq_o),
    .req_o   (rst_req_o)
  );

  rcr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W)) i_rmux (
    .addr_i   (reg_addr_i),
    .ver_i    (VER_WORD),
    .param_i  (PARAM_WORD),
    .last_i   (last_w),
    .sticky_i (sticky_w),
    .ien_i    (ien_q),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/reset_cause_rec_chk.sv
module reset_cause_rec_chk #(
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      EVT_W     = 14,
  parameter logic [EVT_W-1:0] IMPL_MASK = 14'h2FEE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EVT_W-1:0]  evt_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] ien_q,
  input logic [EVT_W-1:0]  last_w,
  input logic [EVT_W-1:0]  sticky_w
);
  import rcr_pkg::*;

  localparam logic [EVT_W-1:0] VMASK = IMPL_MASK & STAT_MASK[EVT_W-1:0];
  localparam logic [EVT_W-1:0] SMASK = IRQ_SRC[EVT_W-1:0];

  logic past_ok;
  logic [EVT_W-1:0] ev;
  assign ev = evt_i & VMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_rsv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((last_w | sticky_w) & ~VMASK) == '0);

  p_por_both_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ev[BIT_POR]) |->
      last_w == EVT_W'(14'h0082) && sticky_w == EVT_W'(14'h0082));

  p_evt_sticks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(ev) != '0) |-> (sticky_w & $past(ev)) == $past(ev)
      || $past(ev[BIT_POR]));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $rose(irq_o) |->
      $past(ien_q[BIT_GIE]) && ($past(ev & ien_q[EVT_W-1:0] & SMASK) != '0));

  p_req_ends_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rst_req_o |-> $past(irq_o) && !irq_o);

  p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

bind reset_cause_rec reset_cause_rec_chk #(
  .DATA_W(DATA_W), .EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .ien_q(ien_q), .last_w(last_w), .sticky_w(sticky_w)
);

// File: tb/test_reset_cause_rec.sv
module test_reset_cause_rec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt = '0;
  logic        tick = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  reset_cause_rec i_reset_cause_rec (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .lpo_tick_i(tick),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .rst_req_o(req)
  );

  // {event, expected last-cause, expected sticky}
  localparam logic [47:0] VEC [9] = '{
    {16'h0080, 16'h0082, 16'h0082},
    {16'h0004, 16'h0004, 16'h0086},
    {16'h0020, 16'h0020, 16'h00A6},
    {16'h0500, 16'h0500, 16'h05A6},
    {16'h2000, 16'h2000, 16'h25A6},
    {16'h0002, 16'h0002, 16'h25A6},
    {16'h1011, 16'h0002, 16'h25A6},
    {16'h0848, 16'h0848, 16'h2DEE},
    {16'h0280, 16'h0082, 16'h0082}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [13:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic lpo;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_delay(input logic [1:0] sel, input int n, input bit inject);
    wr_reg(5'h1C, 32'h84 | 32'(sel));
    pulse(14'h0004);
    check("R8 irq after enabled event", 32'(irq), 32'd1);
    for (int i = 0; i < n - 1; i++) begin
      lpo();
      if (inject && i == 4) pulse(14'h0004);
    end
    check("R9 no request before last tick", 32'(req), 32'd0);
    check("R10 irq held while counting", 32'(irq), 32'd1);
    lpo();
    check("R9 request after last tick", 32'(req), 32'd1);
    check("R9 irq drops with request", 32'(irq), 32'd0);
    @(negedge clk);
    check("R9 request is one cycle", 32'(req), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R2 constant words
    rd(5'h08, d); check("R11 last-cause after reset", d, 32'h0);
    rd(5'h18, d); check("R11 sticky after reset", d, 32'h0);
    rd(5'h1C, d); check("R11 enables after reset", d, 32'h0);
    check("R11 irq after reset", 32'(irq), 32'd0);
    check("R11 request after reset", 32'(req), 32'd0);
    rd(5'h00, d); check("R2 version word", d, 32'h0100_000B);
    rd(5'h04, d); check("R2 parameter word", d, 32'h0000_2FEE);

    // R1 R3 R4 event table, enables off
    for (int k = 0; k < 9; k++) begin
      pulse(VEC[k][45:32]);
      rd(5'h08, d); check($sformatf("R4 R3 R1 last-cause vec %0d", k), d, 32'(VEC[k][31:16]));
      rd(5'h18, d); check($sformatf("R4 R3 R1 sticky vec %0d", k), d, 32'(VEC[k][15:0]));
      check($sformatf("R8 no irq when disabled vec %0d", k), 32'(irq), 32'd0);
    end

    // R5 clear and read-only
    wr_reg(5'h18, 32'h0000_0002);
    rd(5'h18, d); check("R5 sticky cleared by write-1", d, 32'h0080);
    rd(5'h08, d); check("R5 last-cause untouched by clear", d, 32'h0082);
    wr_reg(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); check("R5 write to last-cause ignored", d, 32'h0082);

    // R6 clear and event in the same cycle
    @(negedge clk);
    addr = 5'h18; wdata = 32'h0000_0084; wr = 1'b1; evt = 14'h0004;
    @(negedge clk);
    wr = 1'b0; evt = '0;
    rd(5'h18, d); check("R6 event wins over clear", d, 32'h0004);

    // R7 writable mask
    wr_reg(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, d); check("R7 enable writable bits", d, 32'h0000_2FEF);

    // R8 gating
    wr_reg(5'h1C, 32'h0000_2F6C);
    pulse(14'h0004);
    check("R8 no irq without global enable", 32'(irq), 32'd0);
    wr_reg(5'h1C, 32'h0000_0084);
    pulse(14'h0008);
    check("R8 no irq for disabled source", 32'(irq), 32'd0);
    pulse(14'h0080);
    check("R8 power-on never interrupts", 32'(irq), 32'd0);

    // R9 R10 delays
    run_delay(2'b00, 10, 1'b1);
    run_delay(2'b01, 34, 1'b0);
    run_delay(2'b10, 130, 1'b0);
    run_delay(2'b11, 514, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule